// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block checks that a watchdog input keeps toggling. Software or a companion device services it by producing any transition, rising or falling. When no transition arrives within the configured timeout, the block raises a single-clock overflow request. The reset controller uses that request to drive a reset pulse of one reset-timeout period.

The watchdog input passes through a two-flop synchronizer. An edge is the XOR of the last synchronized value and the value one clock earlier. A free-running prescaler produces a slow tick, and a tick counter measures the quiet time. Four conditions hold both counters at zero:

- a detected edge;
- an active system reset;
- an asserted manual reset;
- the enable input being low, which stands in for an unconnected watchdog pin.

Because the controller's reset pulse holds the timer cleared, counting starts again from zero once that pulse ends. The nominal timeout is 1.6 s, with an acceptable window of 1.3 s to 1.9 s. The default parameters give 1600 ticks of 1 ms at a 125 MHz clock.

All pins are plain control signals. There is no streamed data, so no valid/ready handshake and no back-pressure.

Top module: `wdog_edge_timer`

## Requirements
- R1: While `rst_n` is low, `wd_overflow` is 0, and both counters and the synchronizer flops are zero.
- R2: With no clearing condition present, `wd_overflow` goes high for exactly one clock on the `PRESCALE*TIMEOUT_TICKS`-th clock edge after the last edge at which a clearing condition was sampled.
- R3: A rising transition on `wd_in` clears the timer. The edge is seen on the third clock edge after the change, once the two synchronizer flops and the history flop have captured it.
- R4: A falling transition on `wd_in` clears the timer in the same way as a rising one.
- R5: While `sys_rst_active` is 1, the timer stays cleared and `wd_overflow` stays 0. A full timeout is counted again after it drops.
- R6: While `man_rst_active` is 1, the timer stays cleared and `wd_overflow` stays 0. A full timeout is counted again after it drops.
- R7: While `wd_enable` is 0, the watchdog is disabled: no overflow is produced and the timer stays cleared.
- R8: On the cycle of an overflow, the tick counter and the prescaler both return to zero. With no clearing in between, the next overflow follows a full timeout later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_in | input | 1 | Asynchronous watchdog service input |
| wd_enable | input | 1 | 1 = watchdog active, 0 = input treated as unconnected |
| sys_rst_active | input | 1 | 1 while the system reset output is asserted |
| man_rst_active | input | 1 | 1 while the filtered manual reset is asserted |
| wd_overflow | output | 1 | One-clock overflow request to the reset controller |

## Verification
The assertions assume that `sys_rst_active`, `man_rst_active` and `wd_enable` are synchronous to `clk`. Only `wd_in` may change freely, since it passes through the synchronizer.

The stimulus drives every input just after the falling clock edge. It holds each level for at least one full clock, so every change is sampled cleanly at the next rising edge.

Random toggling is sparse, so quiet stretches often run past a full timeout and overflows actually occur. The random reset and disable windows are short and occasional, so the hold behaviour is mixed in without hiding the counting path.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic pin_edge;
    logic sys_hold;
    logic man_hold;
    logic disabled;
  } wdt_clr_t;

  function automatic logic wdt_any_clear(wdt_clr_t c);
    return c.pin_edge | c.sys_hold | c.man_hold | c.disabled;
  endfunction
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain;
  logic              hist;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hist <= 1'b0;
    else        hist <= chain[STAGES-1];

  assign edge_o = chain[STAGES-1] ^ hist;
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  if (DIV == 1) begin : g_pass
    logic unused_ok;
    assign unused_ok = clk ^ rst_n;
    assign tick_o    = ~clr_i;
  end else begin : g_div
    localparam int W = $clog2(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);
    logic [W-1:0] count;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      count <= '0;
      else if (clr_i)  count <= '0;
      else if (tick_o) count <= '0;
      else             count <= count + 1'b1;

    assign tick_o = ~clr_i & (count == LAST);
  end
endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout #(
  parameter int TICKS = 1600,
  localparam int CW = $clog2(TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          expire_o
);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_o    <= '0;
      expire_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o    <= '0;
      expire_o <= 1'b0;
    end else if (tick_i && cnt_o == LAST) begin
      cnt_o    <= '0;
      expire_o <= 1'b1;
    end else begin
      if (tick_i) cnt_o <= cnt_o + 1'b1;
      expire_o <= 1'b0;
    end
endmodule

// File: rtl/wdog_edge_timer.sv
module wdog_edge_timer
  import wdt_pkg::*;
#(
  parameter int PRESCALE      = 125000,
  parameter int TIMEOUT_TICKS = 1600,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_in,
  input  logic wd_enable,
  input  logic sys_rst_active,
  input  logic man_rst_active,
  output logic wd_overflow
);
  localparam int CW = $clog2(TIMEOUT_TICKS);

  logic          pin_edge;
  logic          tick;
  logic          clr;
  logic [CW-1:0] tick_cnt;
  wdt_clr_t      cause;

  wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(wd_in), .edge_o(pin_edge)
  );

  always_comb begin
    cause.pin_edge = pin_edge;
    cause.sys_hold = sys_rst_active;
    cause.man_hold = man_rst_active;
    cause.disabled = ~wd_enable;
    clr            = wdt_any_clear(cause);
  end

  wdt_prescale #(.DIV(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .tick_o(tick)
  );

  wdt_timeout #(.TICKS(TIMEOUT_TICKS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .tick_i(tick),
    .cnt_o(tick_cnt), .expire_o(wd_overflow)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int TIMEOUT_TICKS = 1600,
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wd_enable,
  input logic          sys_rst_active,
  input logic          man_rst_active,
  input logic          pin_edge,
  input logic [CW-1:0] cnt_q,
  input logic          wd_overflow
);
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_overflow |=> !wd_overflow); // R2
  AST_LAST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    wd_overflow |-> $past(cnt_q) == CW'(TIMEOUT_TICKS - 1)); // R2
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pin_edge |=> (cnt_q == '0 && !wd_overflow)); // R3
  AST_SYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_active |=> !wd_overflow); // R5
  AST_MAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst_active |=> !wd_overflow); // R6
  AST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_enable |=> (!wd_overflow && cnt_q == '0)); // R7
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wd_overflow |-> cnt_q == '0); // R8
endmodule

bind wdog_edge_timer wdt_checker #(
  .TIMEOUT_TICKS(TIMEOUT_TICKS), .CW($clog2(TIMEOUT_TICKS))
) u_chk (
  .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable),
  .sys_rst_active(sys_rst_active), .man_rst_active(man_rst_active),
  .pin_edge(pin_edge), .cnt_q(tick_cnt), .wd_overflow(wd_overflow)
);

// File: tb/sim_wdog_edge_timer.sv
`timescale 1ns/1ps
module sim_wdog_edge_timer;
  localparam int PS = 4;
  localparam int TT = 6;
  localparam int TP = PS * TT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wd_in = 1'b0, wd_enable = 1'b1, sys_rst_active = 1'b0, man_rst_active = 1'b0;
  logic wd_overflow;
  string cur_req = "R1";
  int checks = 0, errors = 0, pulses = 0;

  always #4 clk = ~clk;

  wdog_edge_timer #(.PRESCALE(PS), .TIMEOUT_TICKS(TT)) u0 (
    .clk(clk), .rst_n(rst_n), .wd_in(wd_in), .wd_enable(wd_enable),
    .sys_rst_active(sys_rst_active), .man_rst_active(man_rst_active),
    .wd_overflow(wd_overflow)
  );

  // Expected behaviour from the requirements: 2-flop sync, XOR edge, TP quiet cycles
  logic m_s0, m_s1, m_prev, m_ovf;
  int   m_q;

  function automatic logic clears(logic e, logic s, logic m, logic en);
    return e | s | m | ~en;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_s0 <= 0; m_s1 <= 0; m_prev <= 0; m_q <= 0; m_ovf <= 0;
    end else begin
      m_s0 <= wd_in; m_s1 <= m_s0; m_prev <= m_s1;
      if (clears(m_s1 ^ m_prev, sys_rst_active, man_rst_active, wd_enable)) begin
        m_q <= 0; m_ovf <= 0;
      end else if (m_q == TP - 1) begin
        m_q <= 0; m_ovf <= 1;
      end else begin
        m_q <= m_q + 1; m_ovf <= 0;
      end
    end

  always @(negedge clk) begin
    if (wd_overflow === 1'b1) pulses++;
    if (rst_n) begin
      checks++;
      if (wd_overflow !== m_ovf) begin
        errors++;
        $display("FAIL %s overflow actual %0b expected %0b at %0t", cur_req, wd_overflow, m_ovf, $time);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  int base;

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    check(wd_overflow === 1'b0, "R1", wd_overflow, 0);      // R1 reset state
    rst_n = 1'b1;

    cur_req = "R2"; base = pulses;                          // R2 first timeout
    step(TP + 2);
    check(pulses - base == 1, "R2", pulses - base, 1);

    cur_req = "R8"; base = pulses;                          // R8 periodic restart
    step(2 * TP);
    check(pulses - base == 2, "R8", pulses - base, 2);

    for (int k = 0; k < 4; k++) begin                        // R3 / R4 servicing
      cur_req = "R3"; base = pulses; wd_in = 1'b1; step(TP - 5);
      check(pulses - base == 0, "R3", pulses - base, 0);
      cur_req = "R4"; base = pulses; wd_in = 1'b0; step(TP - 5);
      check(pulses - base == 0, "R4", pulses - base, 0);
    end

    cur_req = "R5"; base = pulses; sys_rst_active = 1'b1;   // R5
    step(3 * TP);
    check(pulses - base == 0, "R5", pulses - base, 0);
    sys_rst_active = 1'b0; base = pulses; step(TP + 2);
    check(pulses - base == 1, "R5", pulses - base, 1);

    cur_req = "R6"; base = pulses; man_rst_active = 1'b1;   // R6
    step(3 * TP);
    check(pulses - base == 0, "R6", pulses - base, 0);
    man_rst_active = 1'b0; base = pulses; step(TP + 2);
    check(pulses - base == 1, "R6", pulses - base, 1);

    cur_req = "R7"; base = pulses; wd_enable = 1'b0;        // R7
    wd_in = 1'b1; step(2 * TP); wd_in = 1'b0; step(2 * TP);
    check(pulses - base == 0, "R7", pulses - base, 0);
    wd_enable = 1'b1; base = pulses; step(TP + 2);
    check(pulses - base == 1, "R7", pulses - base, 1);

    cur_req = "R2 random";                                   // R2 random mix
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom % 100;
      if (r < 3) wd_in = ~wd_in;
      sys_rst_active = ($urandom % 150 == 0) ? 1'b1 : (sys_rst_active && ($urandom % 6 != 0));
      man_rst_active = ($urandom % 170 == 0) ? 1'b1 : (man_rst_active && ($urandom % 6 != 0));
      if ($urandom % 250 == 0) wd_enable = ~wd_enable;
      if (!wd_enable && $urandom % 10 == 0) wd_enable = 1'b1;
      step(1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule